// File: doc/BRIEF.md
# Serial NOR Flash Range Erase Sequencer

This block erases an address range of a serial NOR flash. It works one byte at a time through an external SPI shifter. A request gives a start address and a byte length. Configuration inputs give the erase granularity, the number of address bytes, the device capacity and a poll time limit. The block checks the range first. A range that is out of bounds, misaligned or empty is refused at once and causes no bus traffic.

An accepted range covering the whole device becomes a single chip-erase command. Any other range becomes a series of block erases. Before every erase command, the block reads the status register until the device reports idle, then sends a standalone write-enable. Each command goes out as its own frame: the shifter ends chip select after the byte flagged as last.

When the last erase command has gone out, the block gives a one-cycle done pulse. When a request is refused, or when the device stays busy past the poll limit, it gives a one-cycle fail pulse instead.

Top module: `spi_nor_erase_seq`

## Requirements
- R1: A request made while idle is refused with a fail pulse, and sends no byte, if the length is zero, if address plus length exceeds the device size, or if the address or the length is not a multiple of the erase size.
- R2: Before each erase, the block sends status-read frames of two bytes, 0x05 then 0x00 (the last byte). It repeats them until bit 0 of the byte received for the second position reads 0.
- R3: After each successful poll, the block sends a one-byte frame 0x06 before the erase frame.
- R4: A length equal to the device size produces one single-byte frame 0xC7 and no address.
- R5: In small-sector mode (cfg_small=1), a block erase uses opcode 0x20 and an erase size of 4096. Otherwise it uses opcode 0xD8 and an erase size of 2^cfg_sect_log2.
- R6: A block erase frame is the opcode followed by the low cfg_addr_bytes (1 to 3) bytes of the block address, most significant first.
- R7: Blocks are erased in ascending order, the address stepping by the erase size until the length is used up. Each block gets its own poll and write-enable. A done pulse follows the reply to the last erase byte.
- R8: If the device still reports busy at the end of a poll frame after more than cfg_timeout cycles of polling for the current erase, the block pulses fail, sets err_timeout, sends no further byte and returns to idle.
- R9: tx_valid stays high, with tx_data and tx_last unchanged, until tx_ready. After each accepted byte, the next byte waits for rx_valid.
- R10: busy is high from acceptance until the done or fail pulse. Requests made while busy are ignored. err_timeout clears on the next request made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request strobe |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| cfg_small | input | 1 | 1 selects 4 KiB erases with opcode 0x20 |
| cfg_sect_log2 | input | SL_W | log2 of the sector size used with opcode 0xD8 |
| cfg_addr_bytes | input | 2 | Address bytes per command, 1 to 3 |
| cfg_dev_size | input | LEN_W | Device capacity in bytes |
| cfg_timeout | input | TO_W | Poll limit in clock cycles per erase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle refusal or timeout pulse |
| err_timeout | output | 1 | Last sequence ended by poll timeout |
| tx_valid | output | 1 | Byte offered to shifter |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of frame; chip select ends after it |
| tx_ready | input | 1 | Shifter takes the byte |
| rx_valid | input | 1 | Byte exchange complete |
| rx_data | input | 8 | Byte received during the exchange |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- the byte handshake holds its value while stalled, and only one byte is ever outstanding;
- done and fail never occur together;
- busy falls only with one of those pulses;
- err_timeout rises only with fail.

Frame contents need the bench's scenarios to show them. A flash model returns a programmed number of busy polls and records every frame, which covers opcode choice, address byte order and width, block stepping, the chip-erase decision, refusal of bad ranges, the poll timeout and requests ignored mid-sequence.

// File: rtl/spi_nor_erase_seq.sv
module spi_nor_erase_seq #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 25,
  parameter int TO_W   = 32,
  parameter int SL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_small,
  input  logic [SL_W-1:0]   cfg_sect_log2,
  input  logic [1:0]        cfg_addr_bytes,
  input  logic [LEN_W-1:0]  cfg_dev_size,
  input  logic [TO_W-1:0]   cfg_timeout,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              err_timeout,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data
);
  localparam int W = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;
  typedef enum logic [1:0] {PH_POLL, PH_WREN, PH_ERASE} ph_t;

  st_t              st;
  ph_t              ph;
  logic [1:0]       idx, nbytes_r, last_idx;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0] remain, esize;
  logic [7:0]       op_r, addr_byte;
  logic             chip_r;
  logic [TO_W-1:0]  to_cnt, timeout_r;

  wire [LEN_W-1:0] esize_w = cfg_small ? LEN_W'(4096) : (LEN_W'(1) << cfg_sect_log2);
  wire [LEN_W-1:0] emask   = esize_w - LEN_W'(1);
  wire [W-1:0]     end_w   = W'(req_addr) + W'(req_len);
  wire bad_req = (req_len == '0) || (end_w > W'(cfg_dev_size)) ||
                 ((req_len & emask) != '0) || ((LEN_W'(req_addr) & emask) != '0);
  wire whole   = (req_len == cfg_dev_size);

  wire [31:0] a32 = 32'(cur_addr);
  assign addr_byte = 8'(a32 >> {nbytes_r - idx, 3'b000});

  always_comb begin
    case (ph)
      PH_POLL:  last_idx = 2'd1;
      PH_WREN:  last_idx = 2'd0;
      default:  last_idx = chip_r ? 2'd0 : nbytes_r;
    endcase
    case (ph)
      PH_POLL:  tx_data = (idx == 2'd0) ? 8'h05 : 8'h00;
      PH_WREN:  tx_data = 8'h06;
      default:  tx_data = (idx == 2'd0) ? op_r : addr_byte;
    endcase
  end

  assign tx_valid = (st == S_SEND);
  assign tx_last  = (idx == last_idx);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_POLL; idx <= '0; nbytes_r <= 2'd3;
      cur_addr <= '0; remain <= '0; esize <= '0; op_r <= '0; chip_r <= 1'b0;
      to_cnt <= '0; timeout_r <= '0;
      done <= 1'b0; fail <= 1'b0; err_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (busy && ph == PH_POLL && to_cnt != '1) to_cnt <= to_cnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          err_timeout <= 1'b0;
          if (bad_req) fail <= 1'b1;
          else begin
            st        <= S_SEND;
            ph        <= PH_POLL;
            idx       <= '0;
            to_cnt    <= '0;
            cur_addr  <= req_addr;
            remain    <= req_len;
            esize     <= esize_w;
            nbytes_r  <= cfg_addr_bytes;
            timeout_r <= cfg_timeout;
            chip_r    <= whole;
            op_r      <= whole ? 8'hC7 : (cfg_small ? 8'h20 : 8'hD8);
          end
        end
        S_SEND: if (tx_ready) st <= S_WAIT;
        default: if (rx_valid) begin
          st <= S_SEND;
          if (idx != last_idx) idx <= idx + 1'b1;
          else begin
            idx <= '0;
            case (ph)
              PH_POLL:
                if (!rx_data[0]) ph <= PH_WREN;
                else if (to_cnt >= timeout_r) begin
                  st <= S_IDLE; fail <= 1'b1; err_timeout <= 1'b1;
                end
              PH_WREN: ph <= PH_ERASE;
              default:
                if (chip_r || remain == esize) begin
                  st <= S_IDLE; done <= 1'b1;
                end else begin
                  cur_addr <= cur_addr + ADDR_W'(esize);
                  remain   <= remain - esize;
                  ph       <= PH_POLL;
                  to_cnt   <= '0;
                end
            endcase
          end
        end
      endcase
    end
  end

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid);
  a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fail));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r8_flag_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> fail);
  a_r9_no_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);
endmodule

// File: tb/spi_nor_erase_seq_bench.sv
module spi_nor_erase_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [24:0] req_len = '0;
  logic cfg_small = 1'b0;
  logic [4:0] cfg_sect_log2 = 5'd12;
  logic [1:0] cfg_addr_bytes = 2'd3;
  logic [24:0] cfg_dev_size = 25'h100000;
  logic [31:0] cfg_timeout = 32'd100000;
  logic busy, done, fail, err_timeout, tx_valid, tx_last;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;

  spi_nor_erase_seq u_spi_nor_erase_seq (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] lb [0:8191]; logic ll [0:8191]; int ln = 0;
  logic [7:0] eb [0:8191]; logic el [0:8191]; int en = 0;
  int busy_left = 0, k_after = 0, pend = 0, fidx = 0;
  logic [7:0] frame_op = 8'h00, pend_data = 8'h00;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // flash model on the byte port
  initial begin
    forever begin
      @(negedge clk);
      rx_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin rx_valid = 1'b1; rx_data = pend_data; end
      end
      tx_ready = ($urandom % 4) != 0;
      if (tx_valid && tx_ready) begin
        if (ln < 8192) begin lb[ln] = tx_data; ll[ln] = tx_last; ln++; end
        if (fidx == 0) frame_op = tx_data;
        pend_data = 8'hFF;
        if (frame_op == 8'h05 && fidx == 1) begin
          if (busy_left > 0) begin pend_data = 8'(($urandom & 32'hFE) | 1); busy_left--; end
          else pend_data = 8'($urandom & 32'hFE);
        end
        if (tx_last) begin
          if (frame_op == 8'h20 || frame_op == 8'hD8 || frame_op == 8'hC7) busy_left = k_after;
          fidx = 0;
        end else fidx++;
        pend = 1 + ($urandom % 3);
      end
    end
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic push(input logic [7:0] b, input logic l);
    eb[en] = b; el[en] = l; en++;
  endtask

  task automatic build(input int addr, input int len, input bit sm, input int lg2,
                       input int ab, input int dev, input int b0, input int k);
    int es, nb, a;
    en = 0;
    es = sm ? 4096 : (1 << lg2);
    nb = (len == dev) ? 1 : len / es;
    a = addr;
    for (int i = 0; i < nb; i++) begin
      for (int p = 0; p <= ((i == 0) ? b0 : k); p++) begin push(8'h05, 0); push(8'h00, 1); end
      push(8'h06, 1);
      if (len == dev) push(8'hC7, 1);
      else begin
        push(sm ? 8'h20 : 8'hD8, 0);
        for (int j = 1; j <= ab; j++) push(8'((a >> (8 * (ab - j))) & 255), j == ab);
        a += es;
      end
    end
  endtask

  // kind: 0 refused, 1 success, 2 timeout
  task automatic run(input int addr, input int len, input bit sm, input int lg2, input int ab,
                     input int dev, input int tmo, input int b0, input int k,
                     input int kind, input string req, input bit interfere);
    int cyc; bit got_d, got_f;
    @(negedge clk);
    cfg_small = sm; cfg_sect_log2 = 5'(lg2); cfg_addr_bytes = 2'(ab);
    cfg_dev_size = 25'(dev); cfg_timeout = 32'(tmo);
    busy_left = b0; k_after = k; ln = 0; fidx = 0;
    if (kind == 1) build(addr, len, sm, lg2, ab, dev, b0, k);
    req_addr = 24'(addr); req_len = 25'(len); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    got_d = 0; got_f = 0; cyc = 0;
    while (!done && !fail && cyc < 60000) begin
      if (interfere && cyc == 15) begin
        req_addr = 24'(addr + 4096); req_len = 25'(4096); req_valid = 1'b1;
      end else req_valid = 1'b0;
      @(negedge clk); cyc++;
    end
    req_valid = 1'b0;
    got_d = done; got_f = fail;
    chk(busy == 1'b0, req, "busy low at end", busy, 0);
    if (kind == 0) begin
      chk(got_f && !got_d, req, "refusal pulses fail", got_f, 1);
      chk(ln == 0, req, "no bytes sent when refused", ln, 0);
      chk(err_timeout == 1'b0, req, "no timeout flag on refusal", err_timeout, 0);
    end else if (kind == 1) begin
      chk(got_d && !got_f, req, "done pulse", got_d, 1);
      chk(err_timeout == 1'b0, req, "timeout flag clear", err_timeout, 0);
      begin
        int bad_at; bad_at = -1;
        for (int i = 0; i < en && i < ln; i++)
          if (bad_at < 0 && (lb[i] != eb[i] || ll[i] != el[i])) bad_at = i;
        chk(ln == en, req, "byte count", ln, en);
        if (bad_at >= 0) chk(0, req, "byte value/last mismatch", int'(lb[bad_at]), int'(eb[bad_at]));
        else chk(1, req, "byte stream", 0, 0);
      end
    end else begin
      int other; other = 0;
      for (int i = 0; i < ln; i++) if (lb[i] != 8'h05 && lb[i] != 8'h00) other++;
      chk(got_f && !got_d, req, "timeout fails", got_f, 1);
      chk(err_timeout == 1'b1, req, "timeout flag set", err_timeout, 1);
      chk(other == 0 && ln > 0, req, "only status reads sent", other, 0);
      repeat (10) @(negedge clk);
      chk(ln % 2 == 0 && !tx_valid, req, "silent after timeout", tx_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !done && !fail && !err_timeout, "R10", "reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 whole device
    run(0, 32'h100000, 1, 12, 3, 32'h100000, 100000, 3, 0, 1, "R4", 0);
    // R5 R6 R7 small sectors, 3 address bytes
    run(32'h23000, 3 * 4096, 1, 12, 3, 32'h100000, 100000, 2, 4, 1, "R5_R6_R7", 0);
    // R5 large sectors, 2 address bytes
    run(32'h8000, 2 * 1024, 0, 10, 2, 32'h10000, 100000, 0, 1, 1, "R5_R6", 0);
    // R6 one address byte
    run(64, 3 * 64, 0, 6, 1, 256, 100000, 1, 2, 1, "R6", 0);
    // R2 long poll with status bits other than bit 0 set
    run(32'h1000, 4096, 1, 12, 3, 32'h100000, 100000, 20, 0, 1, "R2_R3", 0);
    // R1 refusals
    run(32'h1000, 0, 1, 12, 3, 32'h100000, 100000, 0, 0, 0, "R1", 0);
    run(32'h1800, 4096, 1, 12, 3, 32'h100000, 100000, 0, 0, 0, "R1", 0);
    run(32'h1000, 2048, 1, 12, 3, 32'h100000, 100000, 0, 0, 0, "R1", 0);
    run(32'hFF000, 2 * 4096, 1, 12, 3, 32'h100000, 100000, 0, 0, 0, "R1", 0);
    // R1 boundary: range ending exactly at device end is accepted
    run(32'hFE000, 2 * 4096, 1, 12, 3, 32'h100000, 100000, 0, 0, 1, "R1", 0);
    // R8 timeout
    run(32'h2000, 4096, 1, 12, 3, 32'h100000, 300, 100000, 0, 2, "R8", 0);
    // R10 flag cleared, request while busy ignored
    run(32'h4000, 2 * 4096, 1, 12, 3, 32'h100000, 100000, 5, 3, 1, "R10", 1);
    // R7 random valid ranges
    for (int t = 0; t < 20; t++) begin
      bit sm; int lg2, es, nb, blk, ab, dev;
      sm = 1'($urandom % 2); lg2 = 8 + ($urandom % 7);
      es = sm ? 4096 : (1 << lg2);
      dev = 32'h100000; nb = 1 + ($urandom % 5);
      blk = $urandom % ((dev / es) - nb);
      ab = 1 + ($urandom % 3);
      run(blk * es, nb * es, sm, lg2, ab, dev, 100000, $urandom % 4, $urandom % 4, 1, "R7", 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule